// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block estimates the frequency of one clock picked from a bank of up to 128 candidate inputs. During a gate window, it counts rising edges of the chosen input. The window length is programmed in microsecond ticks, and each tick is derived from the reference clock by a fixed division ratio. Software drives the block through a few 32-bit words on the reference clock: a control word and a result word. The control word carries the gate length (programmed as the tick count minus one), the source number, the enable, start, repeat and interrupt flags, and a read-only busy flag.

Each candidate input is resynchronized into the reference domain and sampled there. Inputs therefore have to run below half the reference rate. Once a window closes, software converts the count to a frequency by multiplying it by one million and dividing by the window length in microseconds. The count may be off by about one edge. A count stuck at the all-ones value means the window was too long for the source, and software should retry with a shorter window.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the control word (offset 0x4) and the result word (offset 0xC) both read as zero, and `irq` is low.
- R2: The control word has this layout:
  - bits [15:0]: gate length minus one
  - bit 16: enable
  - bit 17: repeat
  - bit 18: interrupt enable
  - bit 19: start
  - bits [26:20]: source number
  - bit 31: busy

  The start bit always reads as 0, and bits 30:27 read as 0. Writes to offsets 0x0, 0x8 or any other offset have no effect, and those offsets read as 0. `rdata` shows the addressed word in the same cycle that `rd_en` is high, and is 0 otherwise.
- R3: A write to the control word that sets both start and enable, while the block is idle, raises busy on that same clock edge. A write with start but without enable leaves the block idle.
- R4: Busy stays high for exactly (gate length field + 1) × TICK_DIV reference cycles. The result word changes only on the edge where busy drops. While busy, a control write cannot change any field except by clearing enable.
- R5: The result equals the number of rising edges of the selected input inside the window, within one edge. An input held constant gives 0.
- R6: The count saturates at 2^CNT_W − 1 and does not wrap.
- R7: When interrupt enable is set, `irq` is high for exactly one cycle, starting on the edge where a window closes. When interrupt enable is clear, `irq` stays low.
- R8: With repeat and enable set, a new window starts as soon as the previous one closes. Busy stays high throughout, and the result and `irq` update once every window length.
- R9: Writing enable as 0 while busy drops busy on that edge. The result keeps its previous value, and no `irq` is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| src_clk | input | NUM_SRC | Candidate clocks to be measured |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Window-complete pulse |

## Verification
Busy is set on the same edge that samples a starting control write. Busy drops, the result loads and `irq` pulses on the edge exactly (gate length + 1) × TICK_DIV cycles after that write. Read data is combinational, so it is valid in the cycle of the strobe. The bench drives and samples only at falling edges. For every window it counts the falling edges seen between the write and the first idle busy reading, and compares that count with the programmed length. It samples `irq` at that same point and once more one cycle later. In repeat mode it counts the cycles between successive `irq` pulses, which pins down the restart cycle.

// File: rtl/clk_freq_meter.sv
module clk_freq_meter #(
  parameter int NUM_SRC  = 128,
  parameter int TICK_DIV = 250,
  parameter int CNT_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic               irq
);
  localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [3:0] A_CTRL = 4'h4;
  localparam logic [3:0] A_RES  = 4'hC;

  logic [15:0]      dur_q, us_q;
  logic             en_q, cont_q, ien_q, busy_q, irq_q;
  logic [6:0]       src_q;
  logic [TW-1:0]    tick_q;
  logic [CNT_W-1:0] cnt_q, res_q, cnt_nxt;
  logic [NUM_SRC-1:0] rise_vec;
  logic [127:0]     rise_all;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], src_clk[i]};
    assign rise_vec[i] = sh[1] & ~sh[2];
  end

  assign rise_all = 128'(rise_vec);

  wire ctrl_wr   = wr_en && (addr == A_CTRL);
  wire start_req = ctrl_wr && !busy_q && wdata[16] && wdata[19];
  wire abort     = ctrl_wr && busy_q && !wdata[16];
  wire tick_end  = (tick_q == TICK_LAST);
  wire done      = busy_q && !abort && tick_end && (us_q == dur_q);
  wire restart   = done && cont_q && en_q;
  wire gate_go   = start_req || restart;

  assign cnt_nxt = (busy_q && rise_all[src_q] && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dur_q <= '0; en_q <= 1'b0; cont_q <= 1'b0; ien_q <= 1'b0; src_q <= '0;
      busy_q <= 1'b0; irq_q <= 1'b0; tick_q <= '0; us_q <= '0;
      cnt_q <= '0; res_q <= '0;
    end else begin
      irq_q <= done && ien_q;
      if (ctrl_wr && !busy_q) begin
        dur_q  <= wdata[15:0];
        en_q   <= wdata[16];
        cont_q <= wdata[17];
        ien_q  <= wdata[18];
        src_q  <= wdata[26:20];
      end else if (abort) begin
        en_q <= 1'b0;
      end
      if (start_req) begin
        busy_q <= 1'b1;
        tick_q <= '0;
        us_q   <= '0;
        cnt_q  <= '0;
      end else if (abort) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (done) begin
          res_q <= cnt_nxt;
          if (restart) begin
            tick_q <= '0;
            us_q   <= '0;
            cnt_q  <= '0;
          end else begin
            busy_q <= 1'b0;
            cnt_q  <= cnt_nxt;
          end
        end else begin
          cnt_q <= cnt_nxt;
          if (tick_end) begin
            tick_q <= '0;
            us_q   <= us_q + 16'd1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      end
    end
  end

  wire [31:0] ctrl_rd = {busy_q, 4'b0, src_q, 1'b0, ien_q, cont_q, en_q, dur_q};

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_CTRL)     rdata = ctrl_rd;
      else if (addr == A_RES) rdata = 32'(res_q);
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/clk_freq_meter_chk.sv
module clk_freq_meter_chk #(
  parameter int TICK_DIV = 250,
  parameter int CNT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic             irq,
  input logic             busy_q,
  input logic             en_q,
  input logic             ien_q,
  input logic [15:0]      dur_q,
  input logic             done,
  input logic             gate_go,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] res_q
);
  logic [31:0] gate_cyc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       gate_cyc <= '0;
    else if (gate_go) gate_cyc <= 32'd1;
    else if (busy_q)  gate_cyc <= gate_cyc + 32'd1;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'h4 && wdata[16] && wdata[19] && !busy_q) |=> busy_q); // R3
  AST_GATE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> gate_cyc == (32'(dur_q) + 32'd1) * 32'(TICK_DIV)); // R4
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(res_q)); // R4
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == '1 && !gate_go) |=> cnt_q == '1); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_q); // R7
  AST_BUSY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> en_q); // R9
endmodule

bind clk_freq_meter clk_freq_meter_chk #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .busy_q(busy_q), .en_q(en_q), .ien_q(ien_q), .dur_q(dur_q),
  .done(done), .gate_go(gate_go), .cnt_q(cnt_q), .res_q(res_q)
);

// File: tb/clk_freq_meter_test.sv
module clk_freq_meter_test;
  localparam int NSRC = 128;
  localparam int TDIV = 4;
  localparam int CW   = 8;
  localparam int NV   = 9;
  localparam int V_SRC [NV] = '{5, 9, 100, 127, 2, 0, 1, 2, 2};
  localparam int V_DUR [NV] = '{29, 49, 19, 34, 9, 9, 9, 125, 199};
  localparam int V_EXP [NV] = '{20, 20, 20, 10, 20, 0, 0, 252, 255};
  localparam int V_TOL [NV] = '{1, 1, 1, 1, 1, 0, 0, 1, 0};
  localparam int V_IEN [NV] = '{1, 0, 1, 0, 1, 1, 0, 1, 0};

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [NSRC-1:0] srcs;
  int tcount = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(negedge clk) tcount <= tcount + 1;

  always_comb begin
    srcs = '0;
    srcs[1]   = 1'b1;
    srcs[2]   = tcount[0];
    srcs[5]   = ((tcount / 3) % 2) == 1;
    srcs[9]   = ((tcount / 5) % 2) == 1;
    srcs[100] = ((tcount / 2) % 2) == 1;
    srcs[127] = ((tcount / 7) % 2) == 1;
  end

  clk_freq_meter #(.NUM_SRC(NSRC), .TICK_DIV(TDIV), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .src_clk(srcs), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a; #1; d = rdata; rd_en = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(4'h4, v);
    while (v[31] && cyc < 5000) begin
      @(negedge clk); cyc++; rd(4'h4, v);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    int cyc, g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'h4, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(4'hC, v); chk(v == 0, "R1 result", v, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, v); chk(v == 0, "R2 offset0", v, 0);
    rd(4'h8, v); chk(v == 0, "R2 offset8", v, 0);
    rd(4'h4, v); chk(v == 0, "R2 ctrl untouched", v, 0);
    wr(4'h4, 32'hF800_0000 | (32'h55 << 20) | (1 << 19) | (1 << 18) | (1 << 17) | 32'hBEEF);
    rd(4'h4, v);
    chk(v == ((32'h55 << 20) | (1 << 18) | (1 << 17) | 32'hBEEF), "R2 readback", v,
        (32'h55 << 20) | (1 << 18) | (1 << 17) | 32'hBEEF);
    rd_en = 1'b0; addr = 4'h4; #1;
    chk(rdata == 0, "R2 no strobe", rdata, 0);
    repeat (30) @(negedge clk);
    rd(4'h4, v); chk(v[31] == 0, "R3 start without enable", v[31], 0);
    chk(irq == 0, "R3 irq idle", irq, 0);

    for (int i = 0; i < NV; i++) begin
      g = (V_DUR[i] + 1) * TDIV;
      wr(4'h4, 0);
      wr(4'h4, (V_SRC[i] << 20) | (V_IEN[i] << 18) | (1 << 19) | (1 << 16) | V_DUR[i]);
      rd(4'h4, v); chk(v[31] == 1, $sformatf("R3 busy vec%0d", i), v[31], 1);
      wait_idle(cyc);
      chk(cyc == g, $sformatf("R4 gate length vec%0d", i), cyc, g);
      chk(irq == V_IEN[i], $sformatf("R7 irq vec%0d", i), irq, V_IEN[i]);
      @(negedge clk);
      chk(irq == 0, $sformatf("R7 one cycle vec%0d", i), irq, 0);
      wr(4'h4, 0);
      rd(4'hC, v);
      chk((int'(v) >= V_EXP[i] - V_TOL[i]) && (int'(v) <= V_EXP[i] + V_TOL[i]),
          $sformatf("%s count vec%0d", (i == NV - 1) ? "R6" : "R5", i), v, V_EXP[i]);
    end

    wr(4'h4, (5 << 20) | (1 << 19) | (1 << 18) | (1 << 17) | (1 << 16) | 14);
    cyc = 0;
    while (!irq && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(irq == 1, "R8 first irq", irq, 1);
    cyc = 0;
    @(negedge clk);
    while (!irq && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(cyc + 1 == 60, "R8 repeat period", cyc + 1, 60);
    rd(4'h4, v); chk(v[31] == 1, "R8 busy held", v[31], 1);
    rd(4'hC, keep);
    chk(keep >= 9 && keep <= 11, "R8 result", keep, 10);
    repeat (10) @(negedge clk);
    wr(4'h4, 0);
    rd(4'h4, v); chk(v[31] == 0, "R9 abort busy", v[31], 0);
    rd(4'hC, v); chk(v == keep, "R9 result kept", v, keep);
    cyc = 0;
    repeat (130) begin @(negedge clk); if (irq) cyc++; end
    chk(cyc == 0, "R9 no irq after abort", cyc, 0);

    wr(4'h4, (9 << 20) | (1 << 19) | (1 << 18) | (1 << 16) | 49);
    repeat (20) @(negedge clk);
    wr(4'h4, 0);
    rd(4'h4, v); chk(v[31] == 0, "R9 single abort", v[31], 0);
    rd(4'hC, v); chk(v == keep, "R9 single result kept", v, keep);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule